// File: doc/BRIEF.md
# Automatic transmit/receive pin switcher

This block drives one 16-bit bank of general-purpose pins toward a plug-in radio board. A chip with four such banks instantiates it four times. Every pin normally shows the bit held in a plain output register. When automatic switching is turned on, a selection register picks pins that instead show one of two stored patterns: a transmit pattern or a receive pattern.

The choice between the two patterns comes from an internal transmit state. That state follows a "transmit FIFO not empty" input, but with separate, programmable clock-tick delays on its rising and falling edges. This lets external switches settle before samples flow, and lets the last samples drain before the pins return to receive.

Software configures the block through a simple register write port. The plain output register is written under a per-bit write mask, so single pins can be changed without a read-modify-write.

Top module: `atr_switch`

## Requirements
- R1: After reset every register is zero, so automatic switching is off and `pins` reads 0x0000.
- R2: A write to address 4 stores `wr_data` into the plain output register only at the bit positions where `wr_bmask` is 1. All other bits keep their value.
- R3: A pin whose selection bit is 0 always shows its plain output register bit. This holds whether switching is on or off and whether the transmit state is high or low.
- R4: With switching on (address 0, bit 0 set) and the transmit state low, a pin whose selection bit (address 1) is 1 shows its receive-pattern bit (address 3).
- R5: With switching on and the transmit state high, a selected pin shows its transmit-pattern bit (address 2).
- R6: With switching off, every pin shows the plain output register, regardless of the selection register and the transmit state.
- R7: With a rise delay of D (address 5, 12 bits), the transmit state goes high after `fifo_busy` has been high for D+1 consecutive sampling edges. `pins` reflects the change one edge later.
- R8: With a fall delay of F (address 6, 12 bits), the transmit state goes low after `fifo_busy` has been low for F+1 consecutive sampling edges. This delay is independent of the rise delay.
- R9: If `fifo_busy` returns to the current transmit state before a pending delay expires, the transmit state does not change and the delay count starts again from zero.
- R10: A delay of zero changes the transmit state on the first edge that samples the new `fifo_busy` level.
- R11: A write to address 7 changes no register. All other register writes (addresses 0, 1, 2, 3, 5, 6) ignore `wr_bmask`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address: 0 control, 1 selection, 2 transmit pattern, 3 receive pattern, 4 plain output, 5 rise delay, 6 fall delay |
| wr_data | input | 16 | Write data |
| wr_bmask | input | 16 | Per-bit write mask, applied only to address 4 |
| fifo_busy | input | 1 | High while the transmit FIFO holds data |
| pins | output | 16 | Registered pin values for the bank |

## Verification
The assertions take for granted that `fifo_busy` and the write port are synchronous to `clk` and stable around each sampling edge. They also assume the delay registers are not rewritten in the middle of a test that measures a delay, since a rewrite would shift the expected switching edge. The stimulus drives every input only on the falling edge. It leaves each delay setting unchanged for the whole sequence that measures it. It holds `fifo_busy` at a level for an exactly counted number of edges to hit the cycle just before and just after each switch.

// File: rtl/atr_pkg.sv
package atr_pkg;
    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        REG_CTRL = 3'd0,
        REG_SEL  = 3'd1,
        REG_TXV  = 3'd2,
        REG_RXV  = 3'd3,
        REG_OUT  = 3'd4,
        REG_RISE = 3'd5,
        REG_FALL = 3'd6
    } reg_addr_e;
endpackage

// File: rtl/atr_regs.sv
module atr_regs
    import atr_pkg::*;
#(
    parameter int WIDTH = 16,
    parameter int DLY_W = 12
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    wr_addr,
    input  logic [WIDTH-1:0]     wr_data,
    input  logic [WIDTH-1:0]     wr_bmask,
    output logic                 enable,
    output logic [WIDTH-1:0]     sel,
    output logic [WIDTH-1:0]     txv,
    output logic [WIDTH-1:0]     rxv,
    output logic [WIDTH-1:0]     outv,
    output logic [DLY_W-1:0]     rise_dly,
    output logic [DLY_W-1:0]     fall_dly
);
    typedef struct packed {
        logic             en;
        logic [WIDTH-1:0] sel;
        logic [WIDTH-1:0] txv;
        logic [WIDTH-1:0] rxv;
        logic [WIDTH-1:0] outv;
        logic [DLY_W-1:0] rise;
        logic [DLY_W-1:0] fall;
    } regs_t;

    regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (wr_en) begin
            case (wr_addr)
                REG_CTRL: regs_d.en   = wr_data[0];
                REG_SEL:  regs_d.sel  = wr_data;
                REG_TXV:  regs_d.txv  = wr_data;
                REG_RXV:  regs_d.rxv  = wr_data;
                REG_OUT:  regs_d.outv = (regs_q.outv & ~wr_bmask) | (wr_data & wr_bmask);
                REG_RISE: regs_d.rise = wr_data[DLY_W-1:0];
                REG_FALL: regs_d.fall = wr_data[DLY_W-1:0];
                default:  regs_d = regs_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign enable   = regs_q.en;
    assign sel      = regs_q.sel;
    assign txv      = regs_q.txv;
    assign rxv      = regs_q.rxv;
    assign outv     = regs_q.outv;
    assign rise_dly = regs_q.rise;
    assign fall_dly = regs_q.fall;

    // R2
    masked_out_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == REG_OUT) |=>
            ((outv & ~$past(wr_bmask)) == ($past(outv) & ~$past(wr_bmask))));
endmodule

// File: rtl/atr_tx_timer.sv
module atr_tx_timer #(
    parameter int DLY_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fifo_busy,
    input  logic [DLY_W-1:0] rise_dly,
    input  logic [DLY_W-1:0] fall_dly,
    output logic             tx_state
);
    typedef struct packed {
        logic             state;
        logic [DLY_W-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;
    logic [DLY_W-1:0] target;

    always_comb begin
        tmr_d  = tmr_q;
        target = tmr_q.state ? fall_dly : rise_dly;
        if (fifo_busy != tmr_q.state) begin
            if (tmr_q.cnt >= target) begin
                tmr_d.state = fifo_busy;
                tmr_d.cnt   = '0;
            end else begin
                tmr_d.cnt = tmr_q.cnt + 1'b1;
            end
        end else begin
            tmr_d.cnt = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    assign tx_state = tmr_q.state;

    // R9
    state_follows_fifo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_state != $past(tx_state)) |-> ($past(fifo_busy) == tx_state));
endmodule

// File: rtl/atr_pin_mux.sv
module atr_pin_mux #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             tx_state,
    input  logic [WIDTH-1:0] sel,
    input  logic [WIDTH-1:0] txv,
    input  logic [WIDTH-1:0] rxv,
    input  logic [WIDTH-1:0] outv,
    output logic [WIDTH-1:0] pins
);
    logic [WIDTH-1:0] pins_d, pins_q;

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        always_comb begin
            if (enable && sel[b]) pins_d[b] = tx_state ? txv[b] : rxv[b];
            else                  pins_d[b] = outv[b];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pins_q <= '0;
        else        pins_q <= pins_d;
    end

    assign pins = pins_q;

    // R6
    disabled_plain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable) |=> (pins == $past(outv)));
    // R3
    unselected_plain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pins & ~$past(sel)) == ($past(outv) & ~$past(sel))));
    // R5
    tx_pattern_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && tx_state) |=> ((pins & $past(sel)) == ($past(txv) & $past(sel))));
    // R4
    rx_pattern_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !tx_state) |=> ((pins & $past(sel)) == ($past(rxv) & $past(sel))));
endmodule

// File: rtl/atr_switch.sv
module atr_switch
    import atr_pkg::*;
#(
    parameter int WIDTH = 16,
    parameter int DLY_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WIDTH-1:0]  wr_data,
    input  logic [WIDTH-1:0]  wr_bmask,
    input  logic              fifo_busy,
    output logic [WIDTH-1:0]  pins
);
    logic             enable;
    logic             tx_state;
    logic [WIDTH-1:0] sel, txv, rxv, outv;
    logic [DLY_W-1:0] rise_dly, fall_dly;

    atr_regs #(.WIDTH(WIDTH), .DLY_W(DLY_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .wr_bmask(wr_bmask), .enable(enable),
        .sel(sel), .txv(txv), .rxv(rxv), .outv(outv),
        .rise_dly(rise_dly), .fall_dly(fall_dly)
    );

    atr_tx_timer #(.DLY_W(DLY_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .fifo_busy(fifo_busy),
        .rise_dly(rise_dly), .fall_dly(fall_dly), .tx_state(tx_state)
    );

    atr_pin_mux #(.WIDTH(WIDTH)) u_mux (
        .clk(clk), .rst_n(rst_n), .enable(enable), .tx_state(tx_state),
        .sel(sel), .txv(txv), .rxv(rxv), .outv(outv), .pins(pins)
    );
endmodule

// File: tb/sim_atr_switch.sv
`timescale 1ns/1ps
module sim_atr_switch;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [15:0] wr_bmask = '0;
    logic        fifo_busy = 1'b0;
    logic [15:0] pins;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    typedef struct {
        logic [15:0] exp;
        string       tag;
    } item_t;
    item_t sb[$];

    always #2.5 clk = ~clk;

    atr_switch u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .wr_bmask(wr_bmask), .fifo_busy(fifo_busy), .pins(pins)
    );

    // expected values under the configuration used below
    localparam logic [15:0] SEL  = 16'h0FF0;
    localparam logic [15:0] TXV  = 16'hAAAA;
    localparam logic [15:0] RXV  = 16'h5555;
    localparam logic [15:0] OUT1 = 16'hF0FF;
    localparam logic [15:0] ERX  = (OUT1 & ~SEL) | (RXV & SEL);
    localparam logic [15:0] ETX  = (OUT1 & ~SEL) | (TXV & SEL);

    task automatic expect_pins(input logic [15:0] e, input string tag);
        item_t it;
        it.exp = e;
        it.tag = tag;
        sb.push_back(it);
    endtask

    // called at a falling edge; returns at the falling edge after pins update
    task automatic wr(input logic [2:0] a, input logic [15:0] d, input logic [15:0] m);
        wr_en = 1'b1; wr_addr = a; wr_data = d; wr_bmask = m;
        @(negedge clk);
        wr_en = 1'b0; wr_bmask = '0;
        @(negedge clk);
    endtask

    task automatic step(input logic [15:0] e, input string tag);
        @(negedge clk);
        expect_pins(e, tag);
    endtask

    // monitor
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (sb.size() > 0) begin
                item_t it;
                it = sb.pop_front();
                checks++;
                if (pins !== it.exp) begin
                    errors++;
                    $display("FAIL %s: pins=%h expected=%h", it.tag, pins, it.exp);
                end
            end
        end
    end

    // watchdog
    initial begin
        #100000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: done=0 expected=1");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        step(16'h0000, "R1 reset");
        step(16'h0000, "R1 reset hold");

        // R2 masked plain writes
        wr(3'd4, 16'h00FF, 16'hFFFF); expect_pins(16'h00FF, "R2 full write");
        wr(3'd4, 16'hFFFF, 16'hF0F0); expect_pins(OUT1, "R2 partial write");

        // configure patterns, switching still off
        wr(3'd1, SEL, 16'h0000);
        wr(3'd2, TXV, 16'h0000);
        wr(3'd3, RXV, 16'h0000); expect_pins(OUT1, "R6 off after config");
        fifo_busy = 1'b1;
        for (int k = 0; k < 4; k++) step(OUT1, "R6 off fifo busy");
        fifo_busy = 1'b0;
        for (int k = 0; k < 3; k++) step(OUT1, "R6 off fifo idle");

        // enable: rx pattern on selected pins
        wr(3'd0, 16'h0001, 16'h0000); expect_pins(ERX, "R4 rx pattern");

        // zero delays
        fifo_busy = 1'b1;
        step(ERX, "R10 rise before");
        step(ETX, "R10 rise zero delay / R5");
        fifo_busy = 1'b0;
        step(ETX, "R10 fall before");
        step(ERX, "R10 fall zero delay");

        // rise delay 4
        wr(3'd5, 16'h0004, 16'h0000); expect_pins(ERX, "R7 setup");
        fifo_busy = 1'b1;
        for (int k = 1; k <= 5; k++) step(ERX, "R7 rise pending");
        step(ETX, "R7 rise after delay");

        // fall delay 2
        wr(3'd6, 16'h0002, 16'h0000); expect_pins(ETX, "R8 setup");
        fifo_busy = 1'b0;
        for (int k = 1; k <= 3; k++) step(ETX, "R8 fall pending");
        step(ERX, "R8 fall after delay");

        // revert before expiry
        fifo_busy = 1'b1;
        for (int k = 1; k <= 3; k++) step(ERX, "R9 short busy");
        fifo_busy = 1'b0;
        for (int k = 1; k <= 6; k++) step(ERX, "R9 reverted");
        fifo_busy = 1'b1;
        for (int k = 1; k <= 5; k++) step(ERX, "R9 restart pending");
        step(ETX, "R9 restart full delay");

        // plain register change while transmitting
        wr(3'd4, 16'h0000, 16'hFFFF); expect_pins(16'h0000 | (TXV & SEL), "R3 unselected follow plain");

        // unused address
        wr(3'd7, 16'hFFFF, 16'hFFFF); expect_pins(TXV & SEL, "R11 unused address ignored");
        // mask ignored for non-plain register
        wr(3'd2, 16'h5555, 16'h0000); expect_pins(16'h5555 & SEL, "R11 bmask ignored on pattern write");

        // disable
        wr(3'd0, 16'h0000, 16'h0000); expect_pins(16'h0000, "R6 disabled");
        step(16'h0000, "R6 disabled hold");

        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule